// File: doc/BRIEF.md
# Split-Section Ripple Binary Counter

This block is a four-bit binary counter built from two sections that count on their own. The low section is a single toggle stage that halves the rate of its count input. The high section is a chain of three toggle stages that divides its own count input by eight. When the low-section output drives the high-section count input, the four outputs together count from 0 to 15 and wrap. The link can be made outside the block, or inside it with a select input.

Both count inputs are asynchronous levels. Each one passes through a two-flop synchronizer on the system clock. A stage advances when its synchronized input goes from 1 to 0, which reproduces the falling-edge toggling of a master-slave flip-flop. Inside the high chain, a stage toggles in the same clock cycle in which the stage below it falls, so a carry crosses the whole chain without extra cycles.

Two clear inputs must both be high to zero the counter. The system reset `rst_n` is synchronous and active low.

Top module: `ripcnt_split`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `q_lo` and `q_hi` are zero after that edge.
- R2: `q_lo` inverts once for each falling edge (1 to 0) of `cnt_a_in`. A rising edge, or a level held high or low, leaves it unchanged.
- R3: With `cascade_en` low, each falling edge of `cnt_b_in` adds one to `q_hi` modulo 8. `q_hi[0]` has weight 1 and `q_hi[2]` has weight 4.
- R4: In the high chain, bit i inverts in the same clock cycle in which bit i-1 goes from 1 to 0. The step from 7 to 0 therefore completes in a single cycle.
- R5: With `cascade_en` low, the two sections are independent: edges on `cnt_a_in` never change `q_hi`, and edges on `cnt_b_in` never change `q_lo`.
- R6: With `cascade_en` low and `cnt_b_in` driven from `q_lo`, the value {`q_hi`,`q_lo`} (`q_lo` as bit 0) steps 0,1,...,15,0 on successive falling edges of `cnt_a_in`.
- R7: With `cascade_en` high, each 1-to-0 transition of `q_lo` advances `q_hi` in the same cycle, and `cnt_b_in` has no effect.
- R8: While `clr_p` and `clr_q` are both high, all outputs go to zero at the next clock edge and stay zero whatever the count inputs do.
- R9: With only one of `clr_p` and `clr_q` high, the counter counts as if neither were high.
- R10: After the clear is released, the count resumes from zero at the next falling edge of a count input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the count inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| cascade_en | input | 1 | High: the low-section output advances the high section internally |
| cnt_a_in | input | 1 | Asynchronous count input of the divide-by-2 section |
| cnt_b_in | input | 1 | Asynchronous count input of the divide-by-8 section |
| clr_p | input | 1 | Clear term; the clear acts only when both terms are high |
| clr_q | input | 1 | Clear term; the clear acts only when both terms are high |
| q_lo | output | 1 | Divide-by-2 output, weight 1 in the cascaded count |
| q_hi | output | HI_WIDTH | Divide-by-8 count; bit 0 has weight 2 in the cascaded count |

## Verification
The bench runs the full 16-state cycle twice: once with the bench routing `q_lo` back to `cnt_b_in`, and once with the internal link turned on while `cnt_b_in` is toggled on purpose. A design that counted on rising edges would be off by half a pulse. A design that lost the same-cycle ripple would leave the 7 to 0 and 15 to 0 wraps stuck at a wrong value. A design that ignored the link select would double-count when `cnt_b_in` is toggled. The clear is driven with each term high alone and then with both high while pulses arrive. An OR in place of the AND would zero a running count, and a clear that did not hold would let pulses through. Rising edges alone and long held levels are sent to catch level-triggered counting.

// File: rtl/ripcnt_pkg.sv
// Package: shared types for the split-section counter.
// Assumes: nothing beyond IEEE 1800-2017 packed structs.
package ripcnt_pkg;
    // Smallest synchronizer depth that still resolves metastability.
    localparam int MIN_SYNC_STAGES = 2;

    // Synchronized view of one asynchronous count input.
    typedef struct packed {
        logic level;   // settled input level
        logic fall;    // one-cycle pulse on a 1 to 0 transition
    } edge_info_t;
endpackage

// File: rtl/cnt_edge_sync.sv
// Module: synchronizes one asynchronous count input and flags its falling edges.
// Assumes: STAGES >= 2; the input stays at each level for more than STAGES+1 clocks.
module cnt_edge_sync
    import ripcnt_pkg::*;
#(
    parameter int STAGES = MIN_SYNC_STAGES
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       din,
    output edge_info_t ev
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] sync_r;
    logic         last_r;

    // Shift the input through the synchronizer and keep the previous settled level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_r <= '0;
            last_r <= 1'b0;
        end else begin
            sync_r <= {sync_r[TOP-1:0], din};
            last_r <= sync_r[TOP];
        end
    end

    // Report the settled level and a falling-edge strobe.
    always_comb begin
        ev.level = sync_r[TOP];
        ev.fall  = last_r & ~sync_r[TOP];
    end

    // R2
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev.fall |=> !ev.fall);
endmodule

// File: rtl/tog_chain.sv
// Module: chain of toggle stages. Stage 0 toggles on the advance strobe, and each
// later stage toggles in the same cycle in which the stage below it falls.
// Assumes: adv is a single-cycle strobe; clr has priority over counting.
module tog_chain #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [WIDTH-1:0] q,
    output logic             carry
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] tgl;

    // Build the toggle enables; stage i falls when it toggles while set.
    assign tgl[0] = adv;
    generate
        for (genvar i = 1; i < WIDTH; i++) begin : g_ripple
            assign tgl[i] = tgl[i-1] & q[i-1];
        end
    endgenerate

    // The top stage falling is the carry out of the chain.
    assign carry = tgl[WIDTH-1] & q[WIDTH-1];

    // Clear or toggle the stage registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q <= '0;
        end else begin
            q <= q ^ tgl;
        end
    end

    // R1
    sys_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (q == '0));
    // R8
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !adv) |=> $stable(q));
    // R3
    count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && adv) |=> (q == $past(q) + ONE));
    // R4
    wrap_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && carry) |=> (q == '0));
endmodule

// File: rtl/ripcnt_split.sv
// Module: two-section ripple counter, divide-by-2 (low) and divide-by-2^HI_WIDTH
// (high), with an optional internal link from the low output into the high section.
// Assumes: count inputs are asynchronous and slow compared with clk.
module ripcnt_split
    import ripcnt_pkg::*;
#(
    parameter int SYNC_STAGES = MIN_SYNC_STAGES,
    parameter int HI_WIDTH    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cascade_en,
    input  logic                cnt_a_in,
    input  logic                cnt_b_in,
    input  logic                clr_p,
    input  logic                clr_q,
    output logic                q_lo,
    output logic [HI_WIDTH-1:0] q_hi
);
    localparam int N_IN = 2;

    logic [N_IN-1:0] raw_in;
    edge_info_t      ev [N_IN];
    logic            clr_all;
    logic            lo_fall;
    logic            hi_adv;
    logic [0:0]      lo_q;
    logic            hi_carry;

    // Index 0 feeds the low section and index 1 feeds the high section.
    assign raw_in  = {cnt_b_in, cnt_a_in};
    // The clear acts only when both terms are high.
    assign clr_all = clr_p & clr_q;

    generate
        for (genvar g = 0; g < N_IN; g++) begin : g_sync
            cnt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (raw_in[g]),
                .ev    (ev[g])
            );
        end
    endgenerate

    tog_chain #(.WIDTH(1)) u_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_all),
        .adv   (ev[0].fall),
        .q     (lo_q),
        .carry (lo_fall)
    );

    // Choose what advances the high section: the low output falling, or input B.
    assign hi_adv = cascade_en ? lo_fall : ev[1].fall;

    tog_chain #(.WIDTH(HI_WIDTH)) u_hi (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_all),
        .adv   (hi_adv),
        .q     (q_hi),
        .carry (hi_carry)
    );

    assign q_lo = lo_q[0];

    // R7
    ext_b_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade_en && !clr_all && !(ev[0].fall && q_lo)) |=> $stable(q_hi));
    // R5
    a_no_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cascade_en && !clr_all && !ev[1].fall) |=> $stable(q_hi));
    // R9
    one_clear_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_p ^ clr_q) && ev[0].fall) |=> (q_lo != $past(q_lo)));
endmodule

// File: tb/ripcnt_split_test.sv
`timescale 1ns/1ps
module ripcnt_split_test;
    localparam int HI_W = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cascade_en = 1'b0;
    logic            a_in = 1'b0;
    logic            b_man = 1'b0;
    logic            ext_link = 1'b0;
    logic            clr_p = 1'b0;
    logic            clr_q = 1'b0;
    logic            b_in;
    logic            q_lo;
    logic [HI_W-1:0] q_hi;

    int checks = 0;
    int errors = 0;

    // The bench can route q_lo back into the B input to make the external link.
    assign b_in = ext_link ? q_lo : b_man;

    always #2 clk = ~clk;

    ripcnt_split #(.SYNC_STAGES(2), .HI_WIDTH(HI_W)) uut (
        .clk(clk), .rst_n(rst_n), .cascade_en(cascade_en),
        .cnt_a_in(a_in), .cnt_b_in(b_in), .clr_p(clr_p), .clr_q(clr_q),
        .q_lo(q_lo), .q_hi(q_hi)
    );

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int full_val();
        return int'({q_hi, q_lo});
    endfunction

    task automatic pulse_a();
        a_in = 1'b1; wait_clk(8);
        a_in = 1'b0; wait_clk(8);
    endtask

    task automatic pulse_b();
        b_man = 1'b1; wait_clk(8);
        b_man = 1'b0; wait_clk(8);
    endtask

    task automatic do_clear();
        clr_p = 1'b1; clr_q = 1'b1; wait_clk(2);
        clr_p = 1'b0; clr_q = 1'b0; wait_clk(1);
    endtask

    initial begin : watchdog
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        wait_clk(4);
        // R1: the system reset zeroes every output
        check("R1 reset state", full_val(), 0);
        rst_n = 1'b1;
        wait_clk(2);

        // R2, R5: divide-by-2 section alone; q_hi must not move
        for (int k = 1; k <= 10; k++) begin
            pulse_a();
            check("R2 q_lo toggle", q_lo, k % 2);
            check("R5 q_hi unaffected by A", q_hi, 0);
        end
        // R2: a rising edge alone and a long high level do not count
        a_in = 1'b1; wait_clk(30);
        check("R2 rise ignored", q_lo, 0);
        a_in = 1'b0; wait_clk(8);
        check("R2 fall after long high", q_lo, 1);

        // R3, R4, R5: divide-by-8 section alone, two full wraps
        for (int k = 1; k <= 17; k++) begin
            pulse_b();
            check("R3 R4 q_hi count", q_hi, k % 8);
            check("R5 q_lo unaffected by B", q_lo, 1);
        end

        // R6: external link gives the full 16-state sequence
        do_clear();
        check("R8 clear to zero", full_val(), 0);
        ext_link = 1'b1;
        for (int k = 1; k <= 33; k++) begin
            pulse_a();
            check("R6 external cascade", full_val(), k % 16);
        end
        ext_link = 1'b0;
        b_man = 1'b0;
        wait_clk(8);

        // R7: internal link, B toggled on purpose and ignored
        do_clear();
        cascade_en = 1'b1;
        for (int k = 1; k <= 17; k++) begin
            pulse_a();
            pulse_b();
            check("R7 internal cascade", full_val(), k % 16);
        end

        // R9: one clear term high alone does not clear or stall
        clr_p = 1'b1; wait_clk(3);
        check("R9 clr_p alone keeps count", full_val(), 1);
        pulse_a();
        check("R9 clr_p alone counts", full_val(), 2);
        clr_p = 1'b0; clr_q = 1'b1;
        pulse_a();
        check("R9 clr_q alone counts", full_val(), 3);
        clr_q = 1'b0;
        cascade_en = 1'b0;

        // R8: both terms high clear and hold against pulses
        clr_p = 1'b1; clr_q = 1'b1; wait_clk(2);
        check("R8 clear", full_val(), 0);
        pulse_a(); pulse_b(); pulse_a();
        check("R8 held during pulses", full_val(), 0);

        // R10: counting resumes from zero after release
        clr_p = 1'b0; clr_q = 1'b0; wait_clk(3);
        check("R10 still zero after release", full_val(), 0);
        pulse_a();
        check("R10 resume low", q_lo, 1);
        pulse_b();
        check("R10 resume high", q_hi, 1);

        // R1: reset in mid-count
        rst_n = 1'b0; wait_clk(2);
        check("R1 reset mid-count", full_val(), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule